// File: doc/BRIEF.md
# Tileable Programmable Crosspoint Switch

This block is a 64-by-64 crosspoint tile. Every data output has its own configuration register that holds the index of the input it follows. The data path from inputs to outputs has no register in it. A configuration write places a source index from the source-select bus into the register that the destination-select bus names. The write happens only while the tile's local strobe is asserted, so several tiles can share both select buses and still be written one at a time.

Tiles are meant to be arranged in a grid to build a larger switch. A column-drive input decides whether the tile drives its data outputs. Tiles in the same row share an output bus, and they receive complementary column-drive levels. The column-drive level therefore acts as the top bit of a wider source address. When the tile is not driving, each bus reports a cleared enable and an all-zero value, so the buses of a row can be OR-combined. A read mode returns the stored index of a chosen output on a readback bus. That bus is gated by a per-tile test strobe, so one readback bus can be shared across tiles as well.

Top module: `xpt_tile`

## Requirements
- R1: A synchronous active-high reset maps every output n to input n. The readback enable is cleared by reset.
- R2: When `wrMode`=1 and `localStrobe`=1 at a rising edge, the register of output `dstSel` is loaded with `srcSel`. From just after that edge, output `dstSel` follows input `srcSel`.
- R3: When `localStrobe`=0, no clock edge changes any routing, whatever the other inputs are.
- R4: When `wrMode`=0, a clock edge does not change any routing, even with `localStrobe`=1.
- R5: Each bit `dataOut[n]` follows `dataIn[src(n)]` in the same cycle, with no clock edge between an input change and the output change.
- R6: When `colDrive`=0, `dataOutEn` is all zeros and `dataOut` is all zeros. When `colDrive`=1, `dataOutEn` is all ones.
- R7: When `wrMode`=0 at a rising edge, the stored index of output `dstSel` is captured. It appears on `rbData` with `rbEn`=1 after that edge when `testStrobe`=1. After an edge with `wrMode`=1, `rbEn` is 0.
- R8: When `testStrobe`=0, `rbEn` and `rbData` are zero at once. The captured index is kept and shows again when `testStrobe` returns to 1.
- R9: In a 2-by-2 grid whose columns get complementary `colDrive` levels, at most one tile enables each bit of a row's shared output bus. The OR-combined row output follows the input chosen by {column-drive level, stored index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 64 | Data inputs |
| wrMode | input | 1 | 1 selects write mode, 0 selects read mode |
| localStrobe | input | 1 | Per-tile strobe that qualifies writes |
| srcSel | input | 6 | Source index to store |
| dstSel | input | 6 | Output to write or to read back |
| colDrive | input | 1 | 1 lets the tile drive its data outputs |
| testStrobe | input | 1 | 1 lets the tile drive the readback bus |
| dataOut | output | 64 | Routed data, zero when not driving |
| dataOutEn | output | 64 | Per-output drive enable |
| rbData | output | 6 | Read-back source index, zero when not enabled |
| rbEn | output | 1 | Readback bus drive enable |

## Verification
Routing changes take effect just after the write edge. Data and gate effects are combinational, so the bench drives one time unit after a rising edge and checks a further time unit later, without waiting for another edge. A readback result is due one edge after the read request. The bench checks right after that edge, and before it, while a new `dstSel` is applied, it confirms that `rbData` still holds the previous value. The grid checks apply both column-drive levels and compare each row's OR-combined bus with the input chosen by the full wider address.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // strobes sent from the control to the datapath
  typedef struct packed {
    logic cfgWrite;   // load one routing register this edge
    logic rbCapture;  // capture a routing register for readback
  } xptCtrl_t;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
(
  input  logic     rst,
  input  logic     wrMode,
  input  logic     localStrobe,
  output xptCtrl_t ctrl
);
  always_comb begin
    ctrl.cfgWrite  = !rst && wrMode && localStrobe;
    ctrl.rbCapture = !rst && !wrMode;
  end
endmodule

// File: rtl/xpt_datapath.sv
module xpt_datapath
  import xpt_pkg::*;
#(
  parameter int N_PORTS = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  xptCtrl_t           ctrl,
  input  logic [N_PORTS-1:0] dataIn,
  input  logic [IDX_W-1:0]   srcSel,
  input  logic [IDX_W-1:0]   dstSel,
  input  logic               colDrive,
  input  logic               testStrobe,
  output logic [N_PORTS-1:0] dataOut,
  output logic [N_PORTS-1:0] dataOutEn,
  output logic [IDX_W-1:0]   rbData,
  output logic               rbEn
);
  logic [IDX_W-1:0] cfgArr [N_PORTS];
  logic [IDX_W-1:0] rbQ;
  logic             rdValid;

  // one routing register and one selector per output
  for (genvar n = 0; n < N_PORTS; n++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        cfgArr[n] <= IDX_W'(n);
      else if (ctrl.cfgWrite && dstSel == IDX_W'(n))
        cfgArr[n] <= srcSel;
    end
    assign dataOut[n]   = colDrive & dataIn[cfgArr[n]];
    assign dataOutEn[n] = colDrive;
  end

  // readback capture, one edge of latency
  always_ff @(posedge clk) begin
    if (rst) begin
      rbQ     <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctrl.rbCapture;
      if (ctrl.rbCapture)
        rbQ <= cfgArr[dstSel];
    end
  end

  assign rbEn   = rdValid & testStrobe;
  assign rbData = rbEn ? rbQ : '0;
endmodule

// File: rtl/xpt_tile.sv
module xpt_tile
  import xpt_pkg::*;
#(
  parameter  int N_PORTS = 64,
  localparam int IDX_W   = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] dataIn,
  input  logic               wrMode,
  input  logic               localStrobe,
  input  logic [IDX_W-1:0]   srcSel,
  input  logic [IDX_W-1:0]   dstSel,
  input  logic               colDrive,
  input  logic               testStrobe,
  output logic [N_PORTS-1:0] dataOut,
  output logic [N_PORTS-1:0] dataOutEn,
  output logic [IDX_W-1:0]   rbData,
  output logic               rbEn
);
  xptCtrl_t ctrl;

  xpt_ctrl u_ctrl (
    .rst(rst), .wrMode(wrMode), .localStrobe(localStrobe), .ctrl(ctrl)
  );

  xpt_datapath #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dataIn(dataIn),
    .srcSel(srcSel), .dstSel(dstSel), .colDrive(colDrive),
    .testStrobe(testStrobe), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .rbData(rbData), .rbEn(rbEn)
  );
endmodule

// File: rtl/xpt_chk.sv
module xpt_chk #(
  parameter  int N_PORTS = 64,
  localparam int IDX_W   = $clog2(N_PORTS)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PORTS-1:0] dataIn,
  input logic               wrMode,
  input logic               localStrobe,
  input logic [IDX_W-1:0]   srcSel,
  input logic [IDX_W-1:0]   dstSel,
  input logic               colDrive,
  input logic               testStrobe,
  input logic [N_PORTS-1:0] dataOut,
  input logic [N_PORTS-1:0] dataOutEn,
  input logic [IDX_W-1:0]   rbData,
  input logic               rbEn
);
  AST_RESET_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && colDrive) |-> (dataOut == dataIn)); // R1

  AST_WRITE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (wrMode && localStrobe) |=> (!colDrive || dataOut[$past(dstSel)] == dataIn[$past(srcSel)])); // R2

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !colDrive |-> (dataOutEn == '0 && dataOut == '0)); // R6

  AST_OUT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    colDrive |-> (&dataOutEn)); // R6

  AST_RB_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !wrMode |=> (rbEn == testStrobe)); // R7

  AST_RB_IDLE: assert property (@(posedge clk) disable iff (rst)
    wrMode |=> !rbEn); // R7

  AST_RB_GATED: assert property (@(posedge clk) disable iff (rst)
    !testStrobe |-> (!rbEn && rbData == '0)); // R8
endmodule

bind xpt_tile xpt_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst(rst), .dataIn(dataIn), .wrMode(wrMode),
  .localStrobe(localStrobe), .srcSel(srcSel), .dstSel(dstSel),
  .colDrive(colDrive), .testStrobe(testStrobe), .dataOut(dataOut),
  .dataOutEn(dataOutEn), .rbData(rbData), .rbEn(rbEn)
);

// File: tb/xpt_tile_tb.sv
module xpt_tile_tb;
  localparam int CLK_P = 10;
  localparam int N  = 64;
  localparam int IW = 6;
  localparam int GN = 8;
  localparam int GW = 3;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // main tile
  logic          rst = 1'b1;
  logic [N-1:0]  dIn = '0;
  logic          wrMode = 1'b1, lStb = 1'b0, colDrive = 1'b1, tStb = 1'b1;
  logic [IW-1:0] src = '0, dst = '0;
  logic [N-1:0]  dOut, dEn;
  logic [IW-1:0] rbData;
  logic          rbEn;

  xpt_tile #(.N_PORTS(N)) u_dut (
    .clk(clk), .rst(rst), .dataIn(dIn), .wrMode(wrMode), .localStrobe(lStb),
    .srcSel(src), .dstSel(dst), .colDrive(colDrive), .testStrobe(tStb),
    .dataOut(dOut), .dataOutEn(dEn), .rbData(rbData), .rbEn(rbEn)
  );

  // 2x2 grid of small tiles: tile t sits in row t/2, column t%2
  logic [2*GN-1:0] gIn = '0;
  logic            gWr = 1'b1, gMsb = 1'b0;
  logic [3:0]      gStb = '0, gTst = '0;
  logic [GW-1:0]   gSrc = '0, gDst = '0;
  logic [GN-1:0]   gOut [4];
  logic [GN-1:0]   gEn  [4];
  logic [GW-1:0]   gRb  [4];
  logic [3:0]      gRbEn;

  for (genvar t = 0; t < 4; t++) begin : g_tile
    xpt_tile #(.N_PORTS(GN)) u_dut (
      .clk(clk), .rst(rst), .dataIn(gIn[(t%2)*GN +: GN]), .wrMode(gWr),
      .localStrobe(gStb[t]), .srcSel(gSrc), .dstSel(gDst),
      .colDrive((t%2 == 1) ? gMsb : ~gMsb), .testStrobe(gTst[t]),
      .dataOut(gOut[t]), .dataOutEn(gEn[t]), .rbData(gRb[t]), .rbEn(gRbEn[t])
    );
  end

  function automatic int mapOf(int n);
    return (n * 5 + 3) % N;
  endfunction

  function automatic logic [N-1:0] routed(logic [N-1:0] v, bit ident);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[n] = ident ? v[n] : v[mapOf(n)];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] exp;
    repeat (3) tick();
    rst = 1'b0;
    dIn = 64'h0123_4567_89AB_CDEF;
    #1;
    // R1 identity after reset
    check(dOut == dIn, "R1 identity", dOut, dIn);
    check(rbEn == 1'b0, "R1 rbEn", N'(rbEn), '0);

    // program main tile
    wrMode = 1'b1;
    lStb = 1'b1;
    for (int n = 0; n < N; n++) begin
      dst = IW'(n);
      src = IW'(mapOf(n));
      tick();
    end
    lStb = 1'b0;

    // R2/R5 walking one over every input, no clock in between
    for (int i = 0; i < N; i++) begin
      dIn = N'(1) << i;
      #1;
      exp = routed(dIn, 1'b0);
      check(dOut == exp, (i == 0) ? "R5 combinational" : "R2 walk", dOut, exp);
    end
    pat = 64'hA5C3_0F96_5A3C_F069;
    dIn = pat;
    #1;
    check(dOut == routed(pat, 1'b0), "R2 pattern", dOut, routed(pat, 1'b0));
    dIn = ~pat;
    #1;
    check(dOut == routed(~pat, 1'b0), "R5 inverted", dOut, routed(~pat, 1'b0));

    // R3 strobe low blocks writes
    dIn = pat;
    wrMode = 1'b1; lStb = 1'b0; dst = 6'd10; src = 6'd0;
    tick();
    check(dOut == routed(pat, 1'b0), "R3 no strobe", dOut, routed(pat, 1'b0));
    // R4 read mode blocks writes
    wrMode = 1'b0; lStb = 1'b1; dst = 6'd11; src = 6'd0;
    tick();
    lStb = 1'b0;
    check(dOut == routed(pat, 1'b0), "R4 read mode", dOut, routed(pat, 1'b0));

    // R6 column drive gating
    colDrive = 1'b0;
    #1;
    check(dEn == '0, "R6 enable off", dEn, '0);
    check(dOut == '0, "R6 data off", dOut, '0);
    colDrive = 1'b1;
    #1;
    check(dEn == '1, "R6 enable on", dEn, '1);

    // R7 readback sweep with one-edge latency
    wrMode = 1'b0;
    dst = 6'd0;
    tick();
    for (int n = 0; n < N; n++) begin
      check(rbEn && rbData == IW'(mapOf(n)), "R7 readback", N'(rbData), N'(mapOf(n)));
      dst = IW'((n + 1) % N);
      #1;
      check(rbData == IW'(mapOf(n)), "R7 latency hold", N'(rbData), N'(mapOf(n)));
      tick();
    end
    wrMode = 1'b1;
    tick();
    check(rbEn == 1'b0, "R7 idle in write", N'(rbEn), '0);

    // R8 test strobe gating and retention
    wrMode = 1'b0; dst = 6'd7;
    tick();
    wrMode = 1'b1;
    tStb = 1'b0;
    #1;
    check(!rbEn && rbData == '0, "R8 gated", N'(rbData), '0);
    wrMode = 1'b0;
    tick();
    tStb = 1'b1;
    #1;
    check(rbEn && rbData == IW'(mapOf(7)), "R8 retained", N'(rbData), N'(mapOf(7)));

    // R9 grid: program each tile alone through its own strobe
    gWr = 1'b1;
    for (int t = 0; t < 4; t++) begin
      gStb = 4'(1 << t);
      for (int n = 0; n < GN; n++) begin
        gDst = GW'(n);
        gSrc = GW'((n + t/2 + 2*(t%2)) % GN);
        tick();
      end
    end
    gStb = '0;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 3; p++) begin
        gMsb = m[0];
        gIn = (p == 0) ? 16'hB38E : (p == 1) ? 16'h4C71 : 16'h0F5A;
        #1;
        for (int r = 0; r < 2; r++) begin
          logic [GN-1:0] comb, expRow;
          comb = gOut[2*r] | gOut[2*r+1];
          for (int n = 0; n < GN; n++)
            expRow[n] = gIn[m*GN + (n + r + 2*m) % GN];
          check((gEn[2*r] & gEn[2*r+1]) == '0 && (gEn[2*r] | gEn[2*r+1]) == '1,
                "R9 single driver", N'({gEn[2*r], gEn[2*r+1]}), N'(8'hFF));
          check(comb == expRow, "R9 row data", N'(comb), N'(expRow));
        end
      end
    end
    // R9 shared readback bus: only the strobed tile drives it
    gWr = 1'b0; gDst = 3'd2; gTst = 4'b0100;
    tick();
    check(gRbEn == 4'b0100 && gRb[2] == 3'd3, "R9 shared readback",
          N'({gRbEn, 1'b0, gRb[2]}), N'({4'b0100, 4'd3}));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule